// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block keeps the processor's program-status word and decides, once per clock, what the core does on a reset, a soft reset, a hardware interrupt, a software interrupt or a return from an exception. For each of these events it produces, one cycle later, a new program counter with a write enable and a link value with a write enable. It also produces a single-cycle mode-switch command that tells the register file which bank to expose, the old status word to be stored as the saved copy of the bank being entered, and the updated status word.

The core supplies the program counter of the instruction being interrupted. On a return it also supplies the saved status word of the mode being left. Entry vectors and link offsets are fixed. The link offset depends on whether the core is in the compact (half-word) instruction state. A soft reset also asks the register file to preset three stack pointers to fixed values.

Top module: `exc_seq`

## Requirements
- R1: While `rst` is high, the block drives `pc_o` = 0x00000004 with `pc_we_o` = 1 and `sts_o` = 0x000000D3. That value is supervisor mode 0x13, with interrupt-disable (bit 7) and fast-interrupt-disable (bit 6) set. During reset, no link write, mode switch or error strobe is driven.
- R2: A soft-reset request takes priority over return, interrupt and software interrupt. One cycle later the block drives `pc_o` = 0x08000004 with `pc_we_o` and `sts_o` = 0x0000005F (system mode 0x1F, only fast-interrupt-disable set). It also pulses `mode_sw_o` with target 0x1F and pulses `sp_preset_o` with the active, interrupt-bank and supervisor-bank stack values 0x03007F00, 0x03007FA0 and 0x03007FE0.
- R3: A hardware interrupt is accepted when `irq_req_i` is high and status bit 7 is clear. One cycle later `pc_o` = 0x1C, and `lr_o` = `pc_cur_i`, plus 2 when status bit 5 (compact state) was set. The mode becomes 0x12, bit 5 is cleared and bit 7 is set. The flag bits 31..27 and bit 6 are kept. The previous status word appears on `spsr_o` with `spsr_we_o`, and `mode_sw_o` pulses with target 0x12.
- R4: While status bit 7 is set, `irq_req_i` has no effect: there is no program-counter or link write and the status word is unchanged.
- R5: A software-interrupt strobe gives `pc_o` = 0xC and `lr_o` = `pc_cur_i` − 4, or − 2 when bit 5 was set. The mode becomes 0x13, bit 5 is cleared and bit 7 is set. The old status is saved and `mode_sw_o` pulses with target 0x13.
- R6: When an accepted hardware interrupt and a software interrupt fall in the same cycle, only the hardware interrupt is taken. The software strobe is dropped.
- R7: A return strobe loads the status word with `ret_status_i` masked to its defined bits (31..27 and 7..0; all other bits read zero). It pulses `mode_sw_o` with the restored mode and writes neither program counter nor link. A return takes priority over both interrupt kinds in the same cycle.
- R8: After a return, a held interrupt request is judged against the restored bit 7. It is taken in the next cycle if that bit is clear, and ignored if it is set.
- R9: A return whose mode field is not one of 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B, 0x1F pulses `ret_err_o` for one cycle. The status word is left unchanged and no mode switch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst_req_i | input | 1 | Soft-reset request |
| irq_req_i | input | 1 | Hardware interrupt request level |
| swi_stb_i | input | 1 | Software-interrupt strobe |
| ret_stb_i | input | 1 | Exception-return strobe |
| ret_status_i | input | 32 | Saved status word restored on return |
| pc_cur_i | input | AW | Program counter of the current instruction |
| pc_o | output | AW | New program counter |
| pc_we_o | output | 1 | Program-counter write enable |
| lr_o | output | AW | Link value |
| lr_we_o | output | 1 | Link write enable |
| mode_sw_o | output | 1 | Mode-switch strobe to the register file |
| mode_tgt_o | output | 5 | Target mode of the switch |
| spsr_we_o | output | 1 | Write enable for the saved status of the mode entered |
| spsr_o | output | 32 | Status word to be saved |
| sp_preset_o | output | 1 | Stack-pointer preset strobe (soft reset) |
| sp_active_o | output | AW | Preset for the active stack pointer |
| sp_irq_o | output | AW | Preset for the interrupt-bank stack pointer |
| sp_svc_o | output | AW | Preset for the supervisor-bank stack pointer |
| ret_err_o | output | 1 | Illegal-mode return error pulse |
| sts_o | output | 32 | Current status word |

## Verification
Two pairs of functions can collide in one cycle. The first is an unmasked interrupt with a software strobe: both are raised in the same cycle, and the bench confirms the interrupt vector, link value and mode and that no second entry follows. The second is a return with a held interrupt request: the bench confirms that the return alone takes effect in the first cycle. It then judges the next cycle against the restored disable bit, expecting an entry when the bit is clear and none when it is set. A soft reset raised together with every other event is also checked to win outright.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int STS_W  = 32;
  localparam int MODE_W = 5;

  // status bit positions
  localparam int B_N = 31;
  localparam int B_Z = 30;
  localparam int B_C = 29;
  localparam int B_V = 28;
  localparam int B_Q = 27;
  localparam int B_I = 7;
  localparam int B_F = 6;
  localparam int B_T = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  // defined bits of the status word
  localparam logic [STS_W-1:0] STS_MASK = 32'hF80000FF;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_SOFT,
    EV_RET,
    EV_IRQ,
    EV_SWI
  } ev_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: mode_legal = 1'b1;
      default:                                          mode_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_seq_pkg::*;
(
  input  logic soft_req,
  input  logic ret_stb,
  input  logic irq_req,
  input  logic irq_mask,
  input  logic swi_stb,
  output ev_e  ev
);

  logic irq_take;
  assign irq_take = irq_req & ~irq_mask;

  // fixed priority: soft reset, return, interrupt, software interrupt
  always_comb begin
    if (soft_req)      ev = EV_SOFT;
    else if (ret_stb)  ev = EV_RET;
    else if (irq_take) ev = EV_IRQ;
    else if (swi_stb)  ev = EV_SWI;
    else               ev = EV_NONE;
  end

endmodule

// File: rtl/exc_link.sv
module exc_link
  import exc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int INS_STEP = 4,
  parameter int CMP_STEP = 2
) (
  input  ev_e           ev,
  input  logic [AW-1:0] pc_cur,
  input  logic          thumb,
  output logic [AW-1:0] lr_val
);

  localparam logic [AW-1:0] STEP_I = AW'(INS_STEP);
  localparam logic [AW-1:0] STEP_C = AW'(CMP_STEP);

  always_comb begin
    case (ev)
      EV_IRQ:  lr_val = thumb ? pc_cur + STEP_C : pc_cur;
      EV_SWI:  lr_val = thumb ? pc_cur - STEP_C : pc_cur - STEP_I;
      default: lr_val = pc_cur;
    endcase
  end

endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ev_e              ev,
  input  logic [STS_W-1:0] ret_status,
  output logic             ret_ok,
  output logic [STS_W-1:0] sts_q
);

  localparam logic [STS_W-1:0] RST_STS  = STS_W'((1 << B_I) | (1 << B_F)) | STS_W'(M_SVC);
  localparam logic [STS_W-1:0] SOFT_STS = STS_W'(1 << B_F) | STS_W'(M_SYS);

  logic [STS_W-1:0] nxt;

  assign ret_ok = mode_legal(ret_status[MODE_W-1:0]);

  always_comb begin
    nxt = sts_q;
    case (ev)
      EV_SOFT: nxt = SOFT_STS;
      EV_RET:  if (ret_ok) nxt = ret_status & STS_MASK;
      EV_IRQ: begin
        nxt[MODE_W-1:0] = M_IRQ;
        nxt[B_T]        = 1'b0;
        nxt[B_I]        = 1'b1;
      end
      EV_SWI: begin
        nxt[MODE_W-1:0] = M_SVC;
        nxt[B_T]        = 1'b0;
        nxt[B_I]        = 1'b1;
      end
      default: nxt = sts_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sts_q <= RST_STS;
    else     sts_q <= nxt;
  end

  // R9
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode_legal(sts_q[MODE_W-1:0]));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_q & ~STS_MASK) == '0);

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   RST_VEC  = 32'h00000004,
  parameter logic [AW-1:0]   SOFT_VEC = 32'h08000004,
  parameter logic [AW-1:0]   IRQ_VEC  = 32'h0000001C,
  parameter logic [AW-1:0]   SWI_VEC  = 32'h0000000C,
  parameter logic [AW-1:0]   SP_ACT   = 32'h03007F00,
  parameter logic [AW-1:0]   SP_IRQ   = 32'h03007FA0,
  parameter logic [AW-1:0]   SP_SVC   = 32'h03007FE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_req_i,
  input  logic              irq_req_i,
  input  logic              swi_stb_i,
  input  logic              ret_stb_i,
  input  logic [31:0]       ret_status_i,
  input  logic [AW-1:0]     pc_cur_i,
  output logic [AW-1:0]     pc_o,
  output logic              pc_we_o,
  output logic [AW-1:0]     lr_o,
  output logic              lr_we_o,
  output logic              mode_sw_o,
  output logic [4:0]        mode_tgt_o,
  output logic              spsr_we_o,
  output logic [31:0]       spsr_o,
  output logic              sp_preset_o,
  output logic [AW-1:0]     sp_active_o,
  output logic [AW-1:0]     sp_irq_o,
  output logic [AW-1:0]     sp_svc_o,
  output logic              ret_err_o,
  output logic [31:0]       sts_o
);

  ev_e             ev;
  logic            ret_ok;
  logic [AW-1:0]   lr_val;
  logic [STS_W-1:0] sts_q;

  exc_arb u_arb (
    .soft_req (soft_rst_req_i),
    .ret_stb  (ret_stb_i),
    .irq_req  (irq_req_i),
    .irq_mask (sts_q[B_I]),
    .swi_stb  (swi_stb_i),
    .ev       (ev)
  );

  exc_link #(.AW(AW)) u_link (
    .ev     (ev),
    .pc_cur (pc_cur_i),
    .thumb  (sts_q[B_T]),
    .lr_val (lr_val)
  );

  exc_status u_sts (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .ret_status (ret_status_i),
    .ret_ok     (ret_ok),
    .sts_q      (sts_q)
  );

  assign sts_o       = sts_q;
  assign sp_active_o = SP_ACT;
  assign sp_irq_o    = SP_IRQ;
  assign sp_svc_o    = SP_SVC;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o        <= RST_VEC;
      pc_we_o     <= 1'b1;
      lr_o        <= '0;
      lr_we_o     <= 1'b0;
      mode_sw_o   <= 1'b0;
      mode_tgt_o  <= M_SVC;
      spsr_we_o   <= 1'b0;
      spsr_o      <= '0;
      sp_preset_o <= 1'b0;
      ret_err_o   <= 1'b0;
    end else begin
      pc_we_o     <= 1'b0;
      lr_we_o     <= 1'b0;
      mode_sw_o   <= 1'b0;
      spsr_we_o   <= 1'b0;
      sp_preset_o <= 1'b0;
      ret_err_o   <= 1'b0;
      case (ev)
        EV_SOFT: begin
          pc_o        <= SOFT_VEC;
          pc_we_o     <= 1'b1;
          lr_o        <= '0;
          spsr_o      <= '0;
          mode_sw_o   <= 1'b1;
          mode_tgt_o  <= M_SYS;
          sp_preset_o <= 1'b1;
        end
        EV_RET: begin
          if (ret_ok) begin
            mode_sw_o  <= 1'b1;
            mode_tgt_o <= ret_status_i[MODE_W-1:0];
          end else begin
            ret_err_o  <= 1'b1;
          end
        end
        EV_IRQ: begin
          pc_o       <= IRQ_VEC;
          pc_we_o    <= 1'b1;
          lr_o       <= lr_val;
          lr_we_o    <= 1'b1;
          spsr_o     <= sts_q;
          spsr_we_o  <= 1'b1;
          mode_sw_o  <= 1'b1;
          mode_tgt_o <= M_IRQ;
        end
        EV_SWI: begin
          pc_o       <= SWI_VEC;
          pc_we_o    <= 1'b1;
          lr_o       <= lr_val;
          lr_we_o    <= 1'b1;
          spsr_o     <= sts_q;
          spsr_we_o  <= 1'b1;
          mode_sw_o  <= 1'b1;
          mode_tgt_o <= M_SVC;
        end
        default: ;
      endcase
    end
  end

  // R3
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_we_o && mode_tgt_o == M_IRQ) |-> !$past(sts_o[B_I]));

  // R5
  entry_state_chk: assert property (@(posedge clk) disable iff (rst)
    lr_we_o |-> (sts_o[B_I] && !sts_o[B_T]));

  // R7
  mode_match_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sw_o |-> (sts_o[MODE_W-1:0] == mode_tgt_o));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ret_err_o |-> (sts_o == $past(sts_o)));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lr_we_o, ret_err_o, sp_preset_o}));

endmodule

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        soft_rst_req_i, irq_req_i, swi_stb_i, ret_stb_i;
  logic [31:0] ret_status_i, pc_cur_i;
  logic [31:0] pc_o, lr_o, spsr_o, sts_o, sp_active_o, sp_irq_o, sp_svc_o;
  logic        pc_we_o, lr_we_o, mode_sw_o, spsr_we_o, sp_preset_o, ret_err_o;
  logic [4:0]  mode_tgt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_seq dut_i (
    .clk(clk), .rst(rst), .soft_rst_req_i(soft_rst_req_i), .irq_req_i(irq_req_i),
    .swi_stb_i(swi_stb_i), .ret_stb_i(ret_stb_i), .ret_status_i(ret_status_i),
    .pc_cur_i(pc_cur_i), .pc_o(pc_o), .pc_we_o(pc_we_o), .lr_o(lr_o),
    .lr_we_o(lr_we_o), .mode_sw_o(mode_sw_o), .mode_tgt_o(mode_tgt_o),
    .spsr_we_o(spsr_we_o), .spsr_o(spsr_o), .sp_preset_o(sp_preset_o),
    .sp_active_o(sp_active_o), .sp_irq_o(sp_irq_o), .sp_svc_o(sp_svc_o),
    .ret_err_o(ret_err_o), .sts_o(sts_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_rst_req_i = 0; irq_req_i = 0; swi_stb_i = 0; ret_stb_i = 0;
  endtask

  // drive a return for one cycle, then sample at next falling edge
  task automatic do_ret(input logic [31:0] st, input logic keep_irq);
    @(negedge clk);
    ret_status_i = st; ret_stb_i = 1; irq_req_i = keep_irq;
    @(negedge clk);
    ret_stb_i = 0;
  endtask

  task automatic t_reset_r1();
    rst = 1; idle_inputs(); ret_status_i = 0; pc_cur_i = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pc", pc_o, 32'h4);
    chk("R1", "pc_we", {31'b0, pc_we_o}, 1);
    chk("R1", "sts", sts_o, 32'hD3);
    chk("R1", "lr_we/mode_sw/err", {29'b0, lr_we_o, mode_sw_o, ret_err_o}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "pc_we after release", {31'b0, pc_we_o}, 0);
  endtask

  task automatic t_irq_masked_r4();
    irq_req_i = 1; pc_cur_i = 32'h80;
    @(negedge clk);
    irq_req_i = 0;
    chk("R4", "pc_we/lr_we", {30'b0, pc_we_o, lr_we_o}, 0);
    chk("R4", "sts", sts_o, 32'hD3);
  endtask

  task automatic t_swi_arm_r5();
    swi_stb_i = 1; pc_cur_i = 32'h100;
    @(negedge clk);
    swi_stb_i = 0;
    chk("R5", "pc", pc_o, 32'hC);
    chk("R5", "lr", lr_o, 32'hFC);
    chk("R5", "sts", sts_o, 32'hD3);
    chk("R5", "spsr", spsr_o, 32'hD3);
    chk("R5", "mode", {26'b0, mode_sw_o, mode_tgt_o}, 32'h33);
  endtask

  task automatic t_ret_r7();
    do_ret(32'hA00F0010, 0);
    chk("R7", "sts masked", sts_o, 32'hA0000010);
    chk("R7", "mode", {26'b0, mode_sw_o, mode_tgt_o}, 32'h30);
    chk("R7", "no pc/lr write", {30'b0, pc_we_o, lr_we_o}, 0);
  endtask

  task automatic t_irq_arm_r3();
    @(negedge clk);
    irq_req_i = 1; pc_cur_i = 32'h200;
    @(negedge clk);
    irq_req_i = 0;
    chk("R3", "pc", pc_o, 32'h1C);
    chk("R3", "lr", lr_o, 32'h200);
    chk("R3", "sts flags kept", sts_o, 32'hA0000092);
    chk("R3", "spsr", spsr_o, 32'hA0000010);
    chk("R3", "we", {29'b0, pc_we_o, lr_we_o, spsr_we_o}, 7);
    chk("R3", "mode", {26'b0, mode_sw_o, mode_tgt_o}, 32'h32);
  endtask

  task automatic t_compact_r3_r5();
    do_ret(32'h30, 0);
    @(negedge clk);
    swi_stb_i = 1; pc_cur_i = 32'h300;
    @(negedge clk);
    swi_stb_i = 0;
    chk("R5", "lr compact", lr_o, 32'h2FE);
    chk("R5", "sts compact cleared", sts_o, 32'h93);
    do_ret(32'h30, 0);
    @(negedge clk);
    irq_req_i = 1; pc_cur_i = 32'h400;
    @(negedge clk);
    irq_req_i = 0;
    chk("R3", "lr compact", lr_o, 32'h402);
    chk("R3", "sts compact cleared", sts_o, 32'h92);
  endtask

  task automatic t_irq_swi_r6();
    do_ret(32'h10, 0);
    @(negedge clk);
    irq_req_i = 1; swi_stb_i = 1; pc_cur_i = 32'h500;
    @(negedge clk);
    irq_req_i = 0; swi_stb_i = 0;
    chk("R6", "pc", pc_o, 32'h1C);
    chk("R6", "lr", lr_o, 32'h500);
    chk("R6", "mode", {27'b0, mode_tgt_o}, 32'h12);
    @(negedge clk);
    chk("R6", "swi dropped", {30'b0, pc_we_o, lr_we_o}, 0);
  endtask

  task automatic t_ret_irq_r8();
    // return with irq held, restored disable clear
    @(negedge clk);
    ret_status_i = 32'h1F; ret_stb_i = 1; irq_req_i = 1; pc_cur_i = 32'h600;
    @(negedge clk);
    ret_stb_i = 0;
    chk("R7", "ret wins sts", sts_o, 32'h1F);
    chk("R7", "ret wins no lr", {31'b0, lr_we_o}, 0);
    @(negedge clk);
    chk("R8", "irq taken after ret", {30'b0, pc_we_o, lr_we_o}, 3);
    chk("R8", "sts", sts_o, 32'h92);
    chk("R8", "spsr", spsr_o, 32'h1F);
    irq_req_i = 0;
    // return with disable set, irq held
    do_ret(32'h9F, 1);
    chk("R8", "sts masked ret", sts_o, 32'h9F);
    @(negedge clk);
    irq_req_i = 0;
    chk("R8", "irq held off", {30'b0, pc_we_o, lr_we_o}, 0);
    chk("R8", "sts unchanged", sts_o, 32'h9F);
  endtask

  task automatic t_bad_ret_r9();
    do_ret(32'h15, 0);
    chk("R9", "err", {31'b0, ret_err_o}, 1);
    chk("R9", "sts", sts_o, 32'h9F);
    chk("R9", "no mode_sw", {31'b0, mode_sw_o}, 0);
    do_ret(32'hF0000000, 0);
    chk("R9", "err mode 0", {31'b0, ret_err_o}, 1);
    chk("R9", "sts mode 0", sts_o, 32'h9F);
    @(negedge clk);
    chk("R9", "err single cycle", {31'b0, ret_err_o}, 0);
  endtask

  task automatic t_soft_r2();
    @(negedge clk);
    soft_rst_req_i = 1; irq_req_i = 1; swi_stb_i = 1; ret_stb_i = 1;
    ret_status_i = 32'h10;
    @(negedge clk);
    idle_inputs();
    chk("R2", "pc", pc_o, 32'h08000004);
    chk("R2", "pc_we/lr_we", {30'b0, pc_we_o, lr_we_o}, 2);
    chk("R2", "sts", sts_o, 32'h5F);
    chk("R2", "mode", {26'b0, mode_sw_o, mode_tgt_o}, 32'h3F);
    chk("R2", "preset", {31'b0, sp_preset_o}, 1);
    chk("R2", "sp active", sp_active_o, 32'h03007F00);
    chk("R2", "sp irq", sp_irq_o, 32'h03007FA0);
    chk("R2", "sp svc", sp_svc_o, 32'h03007FE0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_irq_masked_r4();
    t_swi_arm_r5();
    t_ret_r7();
    t_irq_arm_r3();
    t_compact_r3_r5();
    t_irq_swi_r6();
    t_ret_irq_r8();
    t_bad_ret_r9();
    t_soft_r2();
    t_reset_r1();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule